// File: doc/BRIEF.md
# Vector floating-point scalar move unit

This unit executes the two instructions that carry a single floating-point value between element 0 of a vector register and a 64-bit scalar floating-point register. It accepts one instruction word per `valid_i` strobe, together with the vector configuration, the vector length, the floating-point status field and the precision enables. It decides whether the word is one of its two instructions and whether that instruction is legal. It then issues, one cycle later, either a scalar register write, a vector register write, an illegal-instruction pulse, or nothing.

Read addresses to both register files are driven combinationally from the instruction word, and the read data is expected back in the same cycle. Values narrower than 64 bits are NaN-boxed before they reach the scalar register. Going the other way, the whole destination vector register is rewritten: the element value sits in its low bits and every bit above it is zero.

Top module: `vfp_scalar_mover`

## Requirements
- R1: Vector-to-scalar is decoded from opcode bits[6:0]=1010111, bits[14:12]=001, bits[31:26]=001100, bit 25 set and bits[19:15]=00000. The source vector register is bits[24:20] and the destination scalar register is bits[11:7].
- R2: Scalar-to-vector is decoded from opcode bits[6:0]=1010111, bits[14:12]=101, bits[31:26]=001101, bit 25 set and bits[24:20]=00000. The source scalar register is bits[19:15] and the destination vector register is bits[11:7].
- R3: SEW is encoded as 0=8, 1=16, 2=32 and 3=64 bits. A decoded instruction is legal only when vill is 0, single precision is enabled and SEW code is not 0. Vector-to-scalar additionally needs the 2-bit FS field to be nonzero. An illegal instruction pulses `illegal_o` and writes neither register file.
- R4: For SEW 16 and 32, vector-to-scalar writes the low SEW bits of vector bits[63:0] and sets all upper bits to 1.
- R5: For SEW 64, vector-to-scalar passes all 64 bits when double precision is enabled. Otherwise it writes bits[31:0] with the upper 32 bits set to 1.
- R6: `fs_dirty_o` pulses in exactly the cycles in which a vector-to-scalar write is issued.
- R7: Scalar-to-vector writes the low SEW bits of the scalar into vector bits[SEW-1:0] and zeros all higher bits. For SEW 64 without double precision, the upper 32 bits of the written element are 1.
- R8: Scalar-to-vector with vl equal to 0 produces no vector write and no illegal pulse.
- R9: All outputs except the read addresses appear one cycle after `valid_i`. Synchronous reset clears the write enables and flags. With `valid_i` low, or with a word that matches neither encoding, no write enable and no flag is raised.
- R10: `vrf_raddr_o` equals bits[24:20] and `frf_raddr_o` equals bits[19:15] of the instruction word in the same cycle. Write addresses are taken from bits[11:7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word present |
| insn_i | input | 32 | Instruction word |
| vill_i | input | 1 | Vector configuration invalid |
| sew_i | input | 2 | Element width code |
| vl_i | input | VL_W | Current vector length |
| fs_i | input | 2 | Floating-point status field |
| sp_en_i | input | 1 | Single precision enabled |
| dp_en_i | input | 1 | Double precision enabled |
| vrf_raddr_o | output | 5 | Vector register read address |
| vrf_rdata_i | input | VLEN | Vector register read data |
| vrf_we_o | output | 1 | Vector register write enable |
| vrf_waddr_o | output | 5 | Vector register write address |
| vrf_wdata_o | output | VLEN | Vector register write data |
| frf_raddr_o | output | 5 | Scalar FP register read address |
| frf_rdata_i | input | 64 | Scalar FP register read data |
| frf_we_o | output | 1 | Scalar FP register write enable |
| frf_waddr_o | output | 5 | Scalar FP register write address |
| frf_wdata_o | output | 64 | Scalar FP register write data |
| illegal_o | output | 1 | Illegal instruction pulse |
| fs_dirty_o | output | 1 | FP state dirty pulse |

## Verification
Two functions can fall in the same cycle: the legality gate and the zero-length suppression, on a single scalar-to-vector instruction. Random configurations often combine vill, a disabled single precision or SEW code 0 with vl equal to 0, and directed cases force that pairing. Legality is judged first, so such a cycle must show `illegal_o` high with no vector write. A legal instruction with vl at 0 must show neither.

// File: rtl/vfp_scalar_mover.sv
module vfp_scalar_mover #(
  parameter int VLEN = 128,
  parameter int VL_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic            vill_i,
  input  logic [1:0]      sew_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [1:0]      fs_i,
  input  logic            sp_en_i,
  input  logic            dp_en_i,
  output logic [4:0]      vrf_raddr_o,
  input  logic [VLEN-1:0] vrf_rdata_i,
  output logic            vrf_we_o,
  output logic [4:0]      vrf_waddr_o,
  output logic [VLEN-1:0] vrf_wdata_o,
  output logic [4:0]      frf_raddr_o,
  input  logic [63:0]     frf_rdata_i,
  output logic            frf_we_o,
  output logic [4:0]      frf_waddr_o,
  output logic [63:0]     frf_wdata_o,
  output logic            illegal_o,
  output logic            fs_dirty_o
);
  localparam int EW = 64;
  localparam logic [6:0] OPV = 7'b1010111;

  logic is_opv, dec_v2f, dec_f2v, cfg_ok, v2f_ok, vl_zero;
  logic [EW-1:0] elem0, boxed, scal;
  logic [VLEN-1:0] vwide;

  assign is_opv  = insn_i[6:0] == OPV;
  assign dec_v2f = is_opv && insn_i[14:12] == 3'b001 && insn_i[31:26] == 6'b001100
                   && insn_i[25] && insn_i[19:15] == 5'd0;
  assign dec_f2v = is_opv && insn_i[14:12] == 3'b101 && insn_i[31:26] == 6'b001101
                   && insn_i[25] && insn_i[24:20] == 5'd0;
  assign cfg_ok  = !vill_i && sp_en_i && sew_i != 2'd0;
  assign v2f_ok  = cfg_ok && fs_i != 2'd0;
  assign vl_zero = vl_i == '0;

  assign vrf_raddr_o = insn_i[24:20];
  assign frf_raddr_o = insn_i[19:15];

  assign elem0 = vrf_rdata_i[EW-1:0];

  generate
    if (VLEN > EW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^vrf_rdata_i[VLEN-1:EW];
    end
  endgenerate

  always_comb begin
    case (sew_i)
      2'd1:    boxed = {{48{1'b1}}, elem0[15:0]};
      2'd2:    boxed = {{32{1'b1}}, elem0[31:0]};
      2'd3:    boxed = dp_en_i ? elem0 : {{32{1'b1}}, elem0[31:0]};
      default: boxed = elem0;
    endcase
  end

  assign scal = (sew_i == 2'd3 && !dp_en_i) ? {{32{1'b1}}, frf_rdata_i[31:0]} : frf_rdata_i;

  always_comb begin
    vwide = '0;
    case (sew_i)
      2'd1:    vwide[15:0] = scal[15:0];
      2'd2:    vwide[31:0] = scal[31:0];
      2'd3:    vwide[EW-1:0] = scal;
      default: vwide = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frf_we_o    <= 1'b0;
      fs_dirty_o  <= 1'b0;
      vrf_we_o    <= 1'b0;
      illegal_o   <= 1'b0;
      frf_waddr_o <= '0;
      frf_wdata_o <= '0;
      vrf_waddr_o <= '0;
      vrf_wdata_o <= '0;
    end else begin
      frf_we_o   <= valid_i && dec_v2f && v2f_ok;
      fs_dirty_o <= valid_i && dec_v2f && v2f_ok;
      vrf_we_o   <= valid_i && dec_f2v && cfg_ok && !vl_zero;
      illegal_o  <= valid_i && ((dec_v2f && !v2f_ok) || (dec_f2v && !cfg_ok));
      if (valid_i) begin
        frf_waddr_o <= insn_i[11:7];
        vrf_waddr_o <= insn_i[11:7];
        frf_wdata_o <= boxed;
        vrf_wdata_o <= vwide;
      end
    end
  end

  p_illegal_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !vrf_we_o && !frf_we_o);

  p_one_port_r9: assert property (@(posedge clk) disable iff (rst)
    !(vrf_we_o && frf_we_o));

  p_dirty_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    fs_dirty_o == frf_we_o);

  p_box16_r4: assert property (@(posedge clk) disable iff (rst)
    frf_we_o && $past(sew_i) == 2'd1 |-> &frf_wdata_o[63:16]);

  p_tail_zero_r7: assert property (@(posedge clk) disable iff (rst)
    vrf_we_o && $past(sew_i) == 2'd2 |-> vrf_wdata_o[VLEN-1:32] == '0);

  p_vl_zero_r8: assert property (@(posedge clk) disable iff (rst)
    valid_i && vl_i == '0 |=> !vrf_we_o);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !vrf_we_o && !frf_we_o && !illegal_o && !fs_dirty_o);
endmodule

// File: tb/vfp_scalar_mover_tb.sv
`timescale 1ns/1ps
module vfp_scalar_mover_tb_top;
  localparam int VLEN = 128;
  localparam int VL_W = 16;

  logic clk = 1'b0, rst = 1'b1, valid = 1'b0;
  logic [31:0] insn = '0;
  logic vill = 1'b0, sp = 1'b1, dp = 1'b1;
  logic [1:0] sew = 2'd0, fs = 2'd0;
  logic [VL_W-1:0] vl = '0;
  logic [VLEN-1:0] vdat = '0;
  logic [63:0] fdat = '0;
  logic [4:0] vra, fra, vwa, fwa;
  logic vwe, fwe, ill, dirty;
  logic [VLEN-1:0] vwd;
  logic [63:0] fwd;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vfp_scalar_mover #(.VLEN(VLEN), .VL_W(VL_W)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid), .insn_i(insn), .vill_i(vill),
    .sew_i(sew), .vl_i(vl), .fs_i(fs), .sp_en_i(sp), .dp_en_i(dp),
    .vrf_raddr_o(vra), .vrf_rdata_i(vdat), .vrf_we_o(vwe), .vrf_waddr_o(vwa),
    .vrf_wdata_o(vwd), .frf_raddr_o(fra), .frf_rdata_i(fdat), .frf_we_o(fwe),
    .frf_waddr_o(fwa), .frf_wdata_o(fwd), .illegal_o(ill), .fs_dirty_o(dirty));

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_v2f(input logic [4:0] vs, input logic [4:0] rd);
    return {6'b001100, 1'b1, vs, 5'b00000, 3'b001, rd, 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_f2v(input logic [4:0] rs, input logic [4:0] vd);
    return {6'b001101, 1'b1, 5'b00000, rs, 3'b101, vd, 7'b1010111};
  endfunction

  function automatic logic [63:0] exp_frf(input logic [1:0] s, input bit d,
                                          input logic [VLEN-1:0] v);
    logic [63:0] r;
    r = '1;
    if (s == 2'd3 && d) r = v[63:0];
    else if (s == 2'd1) r[15:0] = v[15:0];
    else r[31:0] = v[31:0];
    return r;
  endfunction

  function automatic logic [VLEN-1:0] exp_vrf(input logic [1:0] s, input bit d,
                                              input logic [63:0] f);
    logic [VLEN-1:0] r;
    logic [63:0] src;
    int n;
    src = f;
    if (s == 2'd3 && !d) src[63:32] = 32'hFFFF_FFFF;
    n = 8 << s;
    r = '0;
    for (int i = 0; i < 64; i++) if (i < n) r[i] = src[i];
    return r;
  endfunction

  task automatic run_op(input logic [31:0] w, input bit vi, input logic [1:0] s,
                        input logic [VL_W-1:0] l, input logic [1:0] f, input bit spe,
                        input bit dpe, input logic [VLEN-1:0] vd, input logic [63:0] fd);
    bit is_v2f, is_f2v, ok, e_fwe, e_vwe, e_ill;
    string tag;
    @(negedge clk);
    insn = w; vill = vi; sew = s; vl = l; fs = f; sp = spe; dp = dpe;
    vdat = vd; fdat = fd; valid = 1'b1;
    #1;
    chk(vra == w[24:20], "R10 vrf_raddr", VLEN'(vra), VLEN'(w[24:20]));
    chk(fra == w[19:15], "R10 frf_raddr", VLEN'(fra), VLEN'(w[19:15]));
    is_v2f = w[6:0] == 7'b1010111 && w[14:12] == 3'b001 && w[31:25] == 7'b0011001
             && w[19:15] == 5'd0;
    is_f2v = w[6:0] == 7'b1010111 && w[14:12] == 3'b101 && w[31:25] == 7'b0011011
             && w[24:20] == 5'd0;
    ok = !vi && spe && s != 2'd0;
    e_fwe = is_v2f && ok && f != 2'd0;
    e_vwe = is_f2v && ok && l != '0;
    e_ill = (is_v2f && !(ok && f != 2'd0)) || (is_f2v && !ok);
    @(negedge clk);
    chk(ill == e_ill, "R3 illegal", VLEN'(ill), VLEN'(e_ill));
    chk(fwe == e_fwe, "R1 frf_we", VLEN'(fwe), VLEN'(e_fwe));
    chk(dirty == e_fwe, "R6 fs_dirty", VLEN'(dirty), VLEN'(e_fwe));
    tag = (is_f2v && l == '0) ? "R8 vrf_we" : "R2 vrf_we";
    chk(vwe == e_vwe, tag, VLEN'(vwe), VLEN'(e_vwe));
    if (e_fwe && fwe) begin
      tag = (s == 2'd3) ? "R5 frf_wdata" : "R4 frf_wdata";
      chk(fwd == exp_frf(s, dpe, vd), tag, VLEN'(fwd), VLEN'(exp_frf(s, dpe, vd)));
      chk(fwa == w[11:7], "R10 frf_waddr", VLEN'(fwa), VLEN'(w[11:7]));
    end
    if (e_vwe && vwe) begin
      chk(vwd == exp_vrf(s, dpe, fd), "R7 vrf_wdata", vwd, exp_vrf(s, dpe, fd));
      chk(vwa == w[11:7], "R10 vrf_waddr", VLEN'(vwa), VLEN'(w[11:7]));
    end
    valid = 1'b0;
    @(negedge clk);
    chk(!vwe && !fwe && !ill && !dirty, "R9 idle", VLEN'({vwe, fwe, ill, dirty}), '0);
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] r;
    for (int k = 0; k < VLEN / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!vwe && !fwe && !ill && !dirty, "R9 reset", VLEN'({vwe, fwe, ill, dirty}), '0);
    rst = 1'b0;
    // directed corners
    run_op(enc_v2f(5'd3, 5'd9), 0, 2'd1, 16'd4, 2'd1, 1, 1, rnd_vec(), 64'h0);
    run_op(enc_v2f(5'd4, 5'd1), 0, 2'd2, 16'd0, 2'd3, 1, 0, rnd_vec(), 64'h0);
    run_op(enc_v2f(5'd5, 5'd2), 0, 2'd3, 16'd1, 2'd2, 1, 1, rnd_vec(), 64'h0);
    run_op(enc_v2f(5'd6, 5'd3), 0, 2'd3, 16'd1, 2'd2, 1, 0, rnd_vec(), 64'h0);
    run_op(enc_v2f(5'd7, 5'd4), 0, 2'd2, 16'd1, 2'd0, 1, 1, rnd_vec(), 64'h0);
    run_op(enc_v2f(5'd7, 5'd4), 0, 2'd0, 16'd1, 2'd1, 1, 1, rnd_vec(), 64'h0);
    run_op(enc_f2v(5'd8, 5'd5), 0, 2'd3, 16'd2, 2'd0, 1, 0, '1, 64'h0123_4567_89AB_CDEF);
    run_op(enc_f2v(5'd8, 5'd6), 0, 2'd1, 16'd2, 2'd0, 1, 1, '1, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op(enc_f2v(5'd9, 5'd7), 0, 2'd2, 16'd0, 2'd1, 1, 1, '1, 64'h1);
    run_op(enc_f2v(5'd9, 5'd7), 1, 2'd2, 16'd0, 2'd1, 1, 1, '1, 64'h1);
    run_op(enc_f2v(5'd9, 5'd7), 0, 2'd2, 16'd3, 2'd1, 0, 1, '1, 64'h1);
    run_op(32'h0000_0057, 0, 2'd2, 16'd3, 2'd1, 1, 1, '1, 64'h1);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int kind;
      kind = $urandom_range(0, 3);
      case (kind)
        0: w = enc_v2f(5'($urandom), 5'($urandom));
        1: w = enc_f2v(5'($urandom), 5'($urandom));
        2: w = $urandom;
        default: begin
          w = ($urandom_range(0, 1) != 0) ? enc_v2f(5'($urandom), 5'($urandom))
                                         : enc_f2v(5'($urandom), 5'($urandom));
          w[$urandom_range(0, 31)] ^= 1'b1;
        end
      endcase
      run_op(w, $urandom_range(0, 7) == 0, 2'($urandom), 
             ($urandom_range(0, 3) == 0) ? '0 : VL_W'($urandom),
             2'($urandom), $urandom_range(0, 7) != 0, $urandom_range(0, 1) != 0,
             rnd_vec(), {$urandom, $urandom});
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule